// File: doc/BRIEF.md
# Charge Command Write Watchdog

This block keeps the two charge command registers, charge current and charge voltage, and watches how often a host refreshes them. A host reaches the block through a one-cycle write strobe with an address and a data word. A slow tick input, made by a prescaler outside the block, advances a timeout counter. A 2-bit select field sets the timeout. If neither command register is written before the selected number of ticks, the block clears the charge-current register to zero, which suspends charging. It then raises a one-cycle expiry pulse and a sticky expired flag.

The timer stays stopped after an expiry. It starts again from zero when the host writes the current register, the voltage register or the select field. The three timeout lengths are parameters given in ticks. The defaults keep a 5 : 88 : 175 ratio, so a tick of one second gives the usual durations and a fast tick shrinks them for simulation.

Top module: `charge_cmd_wdt`

## Requirements
- R1: After reset the select field reads 2'b11, both command registers read zero, and the expired flag and the expiry pulse are low.
- R2: The select field encodes 2'b00 = off, 2'b01 = LIM_SHORT ticks, 2'b10 = LIM_MID ticks and 2'b11 = LIM_LONG ticks. With no restart, expiry happens on the clock edge that samples the limit-th tick after the last restart.
- R3: A write to address ADDR_CUR (default 0) stores wr_data in the charge-current register. A write to address ADDR_VOLT (default 1) stores wr_data in the charge-voltage register. Each such write restarts the count from zero, so refreshes spaced closer than the limit never cause an expiry.
- R4: On expiry the charge-current register becomes zero on the same edge. The charge-voltage register is unchanged.
- R5: The expiry pulse is high for exactly one cycle, on the cycle after the expiring edge. The expired flag rises with it and stays high. While the flag is high the counter does not advance, and no further pulse occurs.
- R6: A write to ADDR_CUR, ADDR_VOLT or ADDR_CTRL clears the expired flag and restarts counting from zero.
- R7: With the select field at 2'b00 the counter is held at zero, and no number of ticks causes an expiry.
- R8: A write to ADDR_CTRL (default 2) loads wr_data[1:0] into the select field and restarts the count from zero. The new limit applies from that point on.
- R9: If a charge-current write lands on the same edge as a tick that would expire the timer, the host value is stored, no expiry occurs and the count restarts.
- R10: Writes to any other address leave every register unchanged and do not restart the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle host write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| tick | input | 1 | Prescaled timebase, one-cycle pulses |
| ichg_cmd | output | DATA_W | Charge-current command register |
| vchg_cmd | output | DATA_W | Charge-voltage command register |
| tmo_sel | output | 2 | Timeout select field |
| expire_pulse | output | 1 | One-cycle expiry indication |
| expired | output | 1 | Sticky expired flag |

## Verification
Every result is due one clock after the edge that samples its cause. A write shows up in the registers and in the cleared flag after that edge. The tick that expires the timer zeroes the current register on the same edge and shows the pulse and the flag for the following cycle. The bench drives each stimulus half a cycle before the edge and steps a behavioural model by exactly one update per edge. It then compares every output against the model at the next falling edge, so each expected value is checked in the cycle it becomes visible. The R9 collision is built by placing the write on the exact tick that reaches the limit.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        SEL_OFF   = 2'b00,
        SEL_SHORT = 2'b01,
        SEL_MID   = 2'b10,
        SEL_LONG  = 2'b11
    } tmo_sel_e;

    localparam int unsigned NUM_RESTART_ADDRS = 3;

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned ADDR_CUR  = 0,
    parameter int unsigned ADDR_VOLT = 1,
    parameter int unsigned ADDR_CTRL = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              expire_hit,
    output logic              restart,
    output logic [DATA_W-1:0] cur_q,
    output logic [DATA_W-1:0] volt_q,
    output tmo_sel_e          sel_q
);

    localparam logic [ADDR_W-1:0] A_CUR  = ADDR_W'(ADDR_CUR);
    localparam logic [ADDR_W-1:0] A_VOLT = ADDR_W'(ADDR_VOLT);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);

    typedef struct packed {
        logic [DATA_W-1:0] cur;
        logic [DATA_W-1:0] volt;
        tmo_sel_e          sel;
    } regs_t;

    regs_t st_d, st_q;

    // Per-address hit vector built over the supervised address list
    logic [NUM_RESTART_ADDRS-1:0] hit_vec;
    logic [ADDR_W-1:0]            addr_tab [NUM_RESTART_ADDRS];

    assign addr_tab[0] = A_CUR;
    assign addr_tab[1] = A_VOLT;
    assign addr_tab[2] = A_CTRL;

    for (genvar g = 0; g < NUM_RESTART_ADDRS; g++) begin : g_dec
        assign hit_vec[g] = wr_en && (wr_addr == addr_tab[g]);
    end

    assign restart = |hit_vec;

    always_comb begin
        st_d = st_q;
        if (expire_hit) begin
            st_d.cur = '0;
        end
        if (hit_vec[0]) begin
            st_d.cur = wr_data;
        end
        if (hit_vec[1]) begin
            st_d.volt = wr_data;
        end
        if (hit_vec[2]) begin
            st_d.sel = tmo_sel_e'(wr_data[1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cur  <= '0;
            st_q.volt <= '0;
            st_q.sel  <= SEL_LONG;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_q  = st_q.cur;
    assign volt_q = st_q.volt;
    assign sel_q  = st_q.sel;

    assert_cur_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CUR) |=> cur_q == $past(wr_data));

    assert_volt_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_VOLT) |=> volt_q == $past(wr_data));

    assert_volt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == A_VOLT) |=> $stable(volt_q));

    assert_ctrl_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CTRL) |=> sel_q == $past(wr_data[1:0]));

    assert_other_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != A_CUR && wr_addr != A_VOLT && wr_addr != A_CTRL && !expire_hit)
        |=> ($stable(cur_q) && $stable(sel_q)));

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int unsigned LIM_SHORT = 5,
    parameter int unsigned LIM_MID   = 88,
    parameter int unsigned LIM_LONG  = 175
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     restart,
    input  tmo_sel_e sel,
    output logic     expire_hit,
    output logic     pulse_q,
    output logic     flag_q
);

    localparam int unsigned LIM_MAX = (LIM_LONG > LIM_MID)
        ? ((LIM_LONG > LIM_SHORT) ? LIM_LONG : LIM_SHORT)
        : ((LIM_MID > LIM_SHORT) ? LIM_MID : LIM_SHORT);
    localparam int unsigned CNT_W = $clog2(LIM_MAX + 1);

    localparam logic [CNT_W-1:0] TOP_SHORT = CNT_W'(LIM_SHORT - 1);
    localparam logic [CNT_W-1:0] TOP_MID   = CNT_W'(LIM_MID - 1);
    localparam logic [CNT_W-1:0] TOP_LONG  = CNT_W'(LIM_LONG - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
        logic             flag;
    } tmr_t;

    tmr_t st_d, st_q;
    logic [CNT_W-1:0] top_val;

    always_comb begin
        unique case (sel)
            SEL_SHORT: top_val = TOP_SHORT;
            SEL_MID:   top_val = TOP_MID;
            SEL_LONG:  top_val = TOP_LONG;
            default:   top_val = '0;
        endcase
    end

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        expire_hit = 1'b0;
        if (restart) begin
            st_d.cnt  = '0;
            st_d.flag = 1'b0;
        end else if (sel == SEL_OFF) begin
            st_d.cnt = '0;
        end else if (!st_q.flag && tick) begin
            if (st_q.cnt == top_val) begin
                expire_hit = 1'b1;
                st_d.cnt   = '0;
                st_d.pulse = 1'b1;
                st_d.flag  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_q = st_q.pulse;
    assign flag_q  = st_q.flag;

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != SEL_OFF) |-> st_q.cnt <= top_val);

    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q);

    assert_flag_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !restart) |=> (flag_q && $stable(st_q.cnt)));

    assert_restart_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!flag_q && st_q.cnt == '0));

    assert_off_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_OFF) |-> (st_q.cnt == '0 && !pulse_q));

    assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !pulse_q);

endmodule

// File: rtl/charge_cmd_wdt.sv
module charge_cmd_wdt
    import wdt_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned ADDR_CUR  = 0,
    parameter int unsigned ADDR_VOLT = 1,
    parameter int unsigned ADDR_CTRL = 2,
    parameter int unsigned LIM_SHORT = 5,
    parameter int unsigned LIM_MID   = 88,
    parameter int unsigned LIM_LONG  = 175
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tick,
    output logic [DATA_W-1:0] ichg_cmd,
    output logic [DATA_W-1:0] vchg_cmd,
    output logic [1:0]        tmo_sel,
    output logic              expire_pulse,
    output logic              expired
);

    logic     restart;
    logic     expire_hit;
    tmo_sel_e sel_q;

    wdt_regs #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .ADDR_CUR (ADDR_CUR),
        .ADDR_VOLT(ADDR_VOLT),
        .ADDR_CTRL(ADDR_CTRL)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .expire_hit(expire_hit),
        .restart   (restart),
        .cur_q     (ichg_cmd),
        .volt_q    (vchg_cmd),
        .sel_q     (sel_q)
    );

    wdt_timer #(
        .LIM_SHORT(LIM_SHORT),
        .LIM_MID  (LIM_MID),
        .LIM_LONG (LIM_LONG)
    ) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .restart   (restart),
        .sel       (sel_q),
        .expire_hit(expire_hit),
        .pulse_q   (expire_pulse),
        .flag_q    (expired)
    );

    assign tmo_sel = sel_q;

    assert_flag_cur_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        expired |-> ichg_cmd == '0);

    assert_pulse_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        expire_pulse |-> expired);

endmodule

// File: tb/test_charge_cmd_wdt.sv
`timescale 1ns/1ps
module test_charge_cmd_wdt;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int L1 = 5;
    localparam int L2 = 88;
    localparam int L3 = 175;
    localparam int TICK_GAP = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              tick = 1'b0;
    logic [DATA_W-1:0] ichg_cmd, vchg_cmd;
    logic [1:0]        tmo_sel;
    logic              expire_pulse, expired;

    always #2.5 clk = ~clk;

    charge_cmd_wdt #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .LIM_SHORT(L1), .LIM_MID(L2), .LIM_LONG(L3)
    ) i_charge_cmd_wdt (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tick(tick), .ichg_cmd(ichg_cmd),
        .vchg_cmd(vchg_cmd), .tmo_sel(tmo_sel),
        .expire_pulse(expire_pulse), .expired(expired)
    );

    // behavioural reference state
    int m_cur, m_volt, m_sel, m_cnt, m_flag, m_pulse;
    int n_vec = 0, n_bad = 0, n_cyc = 0, n_pulses = 0;
    string phase = "R1";
    bit done = 0;

    function automatic int lim_of(int s);
        case (s)
            1: return L1;
            2: return L2;
            3: return L3;
            default: return 0;
        endcase
    endfunction

    task automatic model_reset();
        m_cur = 0; m_volt = 0; m_sel = 3; m_cnt = 0; m_flag = 0; m_pulse = 0;
    endtask

    task automatic model_step(bit t, bit w, int a, int d);
        m_pulse = 0;
        if (w && (a == 0 || a == 1 || a == 2)) begin
            if (a == 0) m_cur = d;
            if (a == 1) m_volt = d;
            if (a == 2) m_sel = d & 3;
            m_cnt = 0;
            m_flag = 0;
        end else if (m_sel == 0) begin
            m_cnt = 0;
        end else if (t && m_flag == 0) begin
            m_cnt++;
            if (m_cnt >= lim_of(m_sel)) begin
                m_cnt = 0; m_cur = 0; m_flag = 1; m_pulse = 1;
            end
        end
    endtask

    task automatic compare();
        n_vec++;
        if (ichg_cmd !== DATA_W'(m_cur) || vchg_cmd !== DATA_W'(m_volt) ||
            tmo_sel !== 2'(m_sel) || expired !== 1'(m_flag) ||
            expire_pulse !== 1'(m_pulse)) begin
            n_bad++;
            $display("FAIL %s: got cur=%h volt=%h sel=%0d flag=%0b pulse=%0b exp cur=%h volt=%h sel=%0d flag=%0d pulse=%0d",
                phase, ichg_cmd, vchg_cmd, tmo_sel, expired, expire_pulse,
                m_cur, m_volt, m_sel, m_flag, m_pulse);
        end
        if (expire_pulse === 1'b1) n_pulses++;
    endtask

    task automatic step(bit t, bit w, int a, int d);
        @(negedge clk);
        tick = t; wr_en = w; wr_addr = ADDR_W'(a); wr_data = DATA_W'(d);
        @(posedge clk);
        model_step(t, w, a, d);
        @(negedge clk);
        tick = 0; wr_en = 0;
        compare();
    endtask

    task automatic run_ticks(int n);
        for (int i = 0; i < n; i++) begin
            for (int j = 0; j < TICK_GAP - 1; j++) step(0, 0, 0, 0);
            step(1, 0, 0, 0);
        end
    endtask

    task automatic check_pulses(int exp_n, string req);
        n_vec++;
        if (n_pulses != exp_n) begin
            n_bad++;
            $display("FAIL %s: pulse count got %0d exp %0d", req, n_pulses, exp_n);
        end
        n_pulses = 0;
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        phase = "R1";
        compare();
        step(0, 0, 0, 0);
        n_pulses = 0;

        phase = "R3";
        step(0, 1, 1, 16'h1234);
        step(0, 1, 0, 16'h0800);
        phase = "R2_R4_R5";
        run_ticks(L3 - 1);
        check_pulses(0, "R2");
        run_ticks(1);
        check_pulses(1, "R4");
        run_ticks(40);
        check_pulses(0, "R5");

        phase = "R6";
        step(0, 1, 1, 16'h2222);
        run_ticks(L3);
        check_pulses(1, "R6");

        phase = "R8";
        step(0, 1, 2, 1);
        run_ticks(L1 + 6);
        check_pulses(1, "R8");
        step(0, 1, 2, 2);
        run_ticks(L2 - 1);
        check_pulses(0, "R8");
        run_ticks(1);
        check_pulses(1, "R8");

        phase = "R3_refresh";
        step(0, 1, 0, 16'h0abc);
        for (int k = 0; k < 4; k++) begin
            run_ticks(L2 - 10);
            step(0, 1, (k % 2), 16'h0100 + k);
        end
        check_pulses(0, "R3");

        phase = "R7";
        step(0, 1, 2, 0);
        run_ticks(300);
        check_pulses(0, "R7");

        phase = "R10";
        step(0, 1, 2, 1);
        run_ticks(3);
        step(0, 1, 5, 16'hdead);
        step(0, 1, 200, 16'hbeef);
        run_ticks(L1 - 4);
        check_pulses(0, "R10");
        run_ticks(1);
        check_pulses(1, "R10");

        phase = "R9";
        step(0, 1, 2, 1);
        run_ticks(L1 - 1);
        step(1, 1, 0, 16'h0555);
        check_pulses(0, "R9");
        run_ticks(L1);
        check_pulses(1, "R9");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 100000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles exp completion", n_cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule